// File: doc/BRIEF.md
# Two-Lane Static Word Memory Model

This block is a clock-sampled, synthesizable stand-in for an asynchronous static RAM with 16-bit words split into a low and a high byte lane. The part is selected only when both of its chip enables are asserted. One of them is active low and the other is active high. Write enable, output enable and the two byte enables are all active low. The bidirectional data bus is split into a write-data input, a read-data output and a per-lane drive indication. A system that would tristate the bus uses that indication to drive a lane, so the block itself needs no tristate logic.

Every control input is sampled on the rising clock edge. A write is open on every sampled cycle in which the write-enable, chip-enable and byte-enable conditions all hold. While the write is open, the address, write data and lane mask are re-registered on each cycle. The word is committed on the edge at which the write is first seen closed. The signal that closes the write does not matter. Read data, lane drive and the standby flag are registered and appear one cycle after the edge that sampled the request.

The storage depth is a parameter, so the model fits a simulator or a small FPGA. The address port keeps its full width, and any bits above the index width are ignored.

Top module: `byte_lane_sram`

## Requirements
- R1: While rst_n is low, at each clock edge `standby` is set to 1 and `lane_oe` and `dout` are cleared to 0. This holds whatever the other inputs are.
- R2: When a sampled edge has `ce_n` high or `ce` low, then after that edge `standby` is 1 and `lane_oe` is 2'b00.
- R3: When a sampled edge has both `lb_n` and `ub_n` high, the part counts as deselected. After that edge `standby` is 1 and `lane_oe` is 2'b00, even if both chip enables are asserted.
- R4: The write window is open on each sampled edge where `ce_n`=0, `ce`=1, `we_n`=0 and at least one byte enable is low. The word is stored on the first edge at which the window is sampled closed. It uses the address, data and byte enables of the last open edge. Changes to `din` on the closing edge, or after it, are not stored. This holds whichever signal closes the window.
- R5: `lb_n` low writes bits 7:0 and `ub_n` low writes bits 15:8. A byte whose enable was high on the last open edge keeps its previous contents.
- R6: A read is sampled when the part is selected, at least one byte enable is low, `we_n`=1 and `oe_n`=0. After that edge, `lane_oe[0]` equals the inverse of `lb_n` and `lane_oe[1]` equals the inverse of `ub_n`. Each driven lane of `dout` carries the stored byte, and each lane that is not driven reads as 0.
- R7: When the part is selected with a byte enable low and both `we_n` and `oe_n` high, then after that edge `lane_oe` is 2'b00 and `standby` is 0.
- R8: While the write window is open, `lane_oe` is 2'b00 and `standby` is 0 after the edge, whatever the value of `oe_n`.
- R9: Address bits at and above IDX_W are ignored. Addresses that are equal in their low IDX_W bits reach the same word.
- R10: A read sampled on the same edge that commits a write to the same word returns the newly committed bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset of control and output state |
| ce_n | input | 1 | Chip enable, active low |
| ce | input | 1 | Chip enable, active high |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| lb_n | input | 1 | Low byte enable (bits 7:0), active low |
| ub_n | input | 1 | High byte enable (bits 15:8), active low |
| addr | input | ADDR_W | Word address; only the low IDX_W bits are decoded |
| din | input | 16 | Write data |
| dout | output | 16 | Registered read data, zero in lanes not driven |
| lane_oe | output | 2 | Per-lane drive indication, bit 0 low lane, bit 1 high lane |
| standby | output | 1 | High while the part is deselected |

## Verification
The hardest case to reach is a read that lands on the very edge that commits a write to the same word. At that edge the array still holds the old value, so the result is only right if the pending bytes are forwarded. The stimulus reaches it by opening a write for one cycle and then, on the next cycle, raising write enable and lowering output enable at the same address. Windows closed by each kind of signal are also driven. In one of them `din` changes on the closing cycle. Each such window is followed by a read that shows which bytes were taken.

// File: rtl/byte_lane_sram.sv
`timescale 1ns/1ps
module byte_lane_sram #(
  parameter int ADDR_W = 20,
  parameter int IDX_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              ce,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              lb_n,
  input  logic              ub_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       din,
  output logic [15:0]       dout,
  output logic [1:0]        lane_oe,
  output logic              standby
);
  localparam int WORDS = 1 << IDX_W;
  localparam int LANES = 2;
  localparam int LW    = 8;

  logic [15:0] mem [WORDS];

  logic [LANES-1:0] ben;
  logic             active, wr_open, rd_go, commit, win_q;
  logic [IDX_W-1:0] idx, cap_idx;
  logic [15:0]      cap_d, old_w, new_w, rd_w;
  logic [LANES-1:0] cap_en;

  assign ben     = ~{ub_n, lb_n};
  assign active  = !ce_n && ce && (ben != '0);
  assign wr_open = active && !we_n;
  assign rd_go   = active && we_n && !oe_n;
  assign commit  = win_q && !wr_open;
  assign idx     = IDX_W'(addr);
  assign old_w   = mem[cap_idx];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign new_w[l*LW +: LW] = cap_en[l] ? cap_d[l*LW +: LW] : old_w[l*LW +: LW];
  end

  assign rd_w = (commit && cap_idx == idx) ? new_w : mem[idx];

  always_ff @(posedge clk)
    if (rst_n && commit) mem[cap_idx] <= new_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_q   <= 1'b0;
      cap_idx <= '0;
      cap_d   <= '0;
      cap_en  <= '0;
    end else begin
      win_q <= wr_open;
      if (wr_open) begin
        cap_idx <= idx;
        cap_d   <= din;
        cap_en  <= ben;
      end
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_out
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        lane_oe[l]         <= 1'b0;
        dout[l*LW +: LW]   <= '0;
      end else begin
        lane_oe[l]         <= rd_go && ben[l];
        dout[l*LW +: LW]   <= (rd_go && ben[l]) ? rd_w[l*LW +: LW] : '0;
      end
    end
  end

  always_ff @(posedge clk)
    if (!rst_n) standby <= 1'b1;
    else        standby <= !active;
endmodule

// File: rtl/byte_lane_sram_chk.sv
`timescale 1ns/1ps
module byte_lane_sram_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n,
  input logic              ce,
  input logic              we_n,
  input logic              oe_n,
  input logic              lb_n,
  input logic              ub_n,
  input logic [ADDR_W-1:0] addr,
  input logic [15:0]       din,
  input logic [15:0]       dout,
  input logic [1:0]        lane_oe,
  input logic              standby
);
  logic sel;
  assign sel = !ce_n && ce;

  AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> (standby && lane_oe == 2'b00)); // R2

  AST_BYTES_OFF_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
    (lb_n && ub_n) |=> (standby && lane_oe == 2'b00)); // R3

  AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !we_n && !(lb_n && ub_n)) |=> (lane_oe == 2'b00 && !standby)); // R8

  AST_OUT_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && we_n && oe_n && !(lb_n && ub_n)) |=> (lane_oe == 2'b00 && !standby)); // R7

  AST_READ_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && we_n && !oe_n && !(lb_n && ub_n)) |=> (lane_oe == ~$past({ub_n, lb_n}))); // R6

  AST_STANDBY_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    standby |-> (lane_oe == 2'b00 && dout == 16'h0000)); // R2
endmodule

bind byte_lane_sram byte_lane_sram_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_byte_lane_sram.sv
`timescale 1ns/1ps
module tb_byte_lane_sram;
  logic clk = 0, rst_n = 0;
  logic ce_n = 1, ce = 0, we_n = 1, oe_n = 1, lb_n = 1, ub_n = 1;
  logic [19:0] addr = '0;
  logic [15:0] din = '0, dout;
  logic [1:0]  lane_oe;
  logic        standby;

  always #10 clk = ~clk;

  byte_lane_sram dut (.clk, .rst_n, .ce_n, .ce, .we_n, .oe_n, .lb_n, .ub_n,
                      .addr, .din, .dout, .lane_oe, .standby);

  typedef struct packed {
    bit          chk;
    logic        sb;
    logic [1:0]  oe;
    logic [15:0] d;
  } exp_t;

  exp_t  q[$];
  string tq[$];
  int n_run = 0, n_fail = 0;
  bit done = 0;

  task automatic cyc(input logic cen, ci, wen, oen, lbn, ubn,
                     input logic [19:0] a, input logic [15:0] d,
                     input bit chk, input logic esb, input logic [1:0] eoe,
                     input logic [15:0] edo, input string tag);
    exp_t e;
    @(negedge clk);
    ce_n = cen; ce = ci; we_n = wen; oe_n = oen; lb_n = lbn; ub_n = ubn;
    addr = a; din = d;
    e.chk = chk; e.sb = esb; e.oe = eoe; e.d = edo;
    q.push_back(e);
    tq.push_back(tag);
  endtask

  initial begin : monitor
    exp_t  e;
    string t;
    forever begin
      @(posedge clk);
      #5;
      if (q.size() > 0) begin
        e = q.pop_front();
        t = tq.pop_front();
        if (e.chk) begin
          n_run++;
          if (standby !== e.sb || lane_oe !== e.oe || dout !== e.d) begin
            n_fail++;
            $display("FAIL %s: standby=%0b lane_oe=%b dout=%h expected standby=%0b lane_oe=%b dout=%h",
                     t, standby, lane_oe, dout, e.sb, e.oe, e.d);
          end
        end
      end
    end
  end

  initial begin : watchdog
    #(20 * 20000);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : stimulus
    // R1: reset dominates a read request
    cyc(0,1,1,0,0,0,20'd5,16'h0, 1, 1'b1, 2'b00, 16'h0, "R1");
    @(negedge clk); rst_n = 1;
    // R2: idle deselected
    cyc(1,0,1,1,0,0,20'd0,16'h0, 1, 1'b1, 2'b00, 16'h0, "R2");
    // R8: write open with oe_n low, nothing driven
    cyc(0,1,0,0,0,0,20'd5,16'h1234, 1, 1'b0, 2'b00, 16'h0, "R8");
    // R7: close by we_n high with oe_n high, output disabled
    cyc(0,1,1,1,0,0,20'd5,16'h0, 1, 1'b0, 2'b00, 16'h0, "R7");
    // R6: full read, then low lane only
    cyc(0,1,1,0,0,0,20'd5,16'h0, 1, 1'b0, 2'b11, 16'h1234, "R6");
    cyc(0,1,1,0,0,1,20'd5,16'h0, 1, 1'b0, 2'b01, 16'h0034, "R6");
    // R5/R4: high lane write ended by ce_n, din changes on closing edge
    cyc(0,1,0,1,1,0,20'd5,16'hABCD, 1, 1'b0, 2'b00, 16'h0, "R8");
    cyc(1,1,0,1,1,0,20'd5,16'hFFFF, 1, 1'b1, 2'b00, 16'h0, "R2");
    cyc(0,1,1,0,0,0,20'd5,16'h0, 1, 1'b0, 2'b11, 16'hAB34, "R5");
    // R4: window ended by ce going low
    cyc(0,1,0,1,0,0,20'd6,16'h5566, 0, 1'b0, 2'b00, 16'h0, "");
    cyc(0,0,0,1,0,0,20'd6,16'h0, 1, 1'b1, 2'b00, 16'h0, "R2");
    cyc(0,1,1,0,0,0,20'd6,16'h0, 1, 1'b0, 2'b11, 16'h5566, "R4");
    // R3: low-lane write ended by byte enables both high
    cyc(0,1,0,1,0,1,20'd7,16'h7788, 0, 1'b0, 2'b00, 16'h0, "");
    cyc(0,1,0,1,1,1,20'd7,16'h0, 1, 1'b1, 2'b00, 16'h0, "R3");
    cyc(0,1,1,0,0,1,20'd7,16'h0, 1, 1'b0, 2'b01, 16'h0088, "R5");
    // R4: multi-cycle window, last address and data win
    cyc(0,1,0,1,0,0,20'd10,16'h3333, 0, 1'b0, 2'b00, 16'h0, "");
    cyc(0,1,0,1,0,0,20'd9,16'h2222, 0, 1'b0, 2'b00, 16'h0, "");
    cyc(0,1,1,1,0,0,20'd9,16'h0, 0, 1'b0, 2'b00, 16'h0, "");
    cyc(0,1,1,0,0,0,20'd9,16'h0, 1, 1'b0, 2'b11, 16'h2222, "R4");
    // R10: read on the commit edge of the same word
    cyc(0,1,0,1,0,0,20'd8,16'h9ABC, 0, 1'b0, 2'b00, 16'h0, "");
    cyc(0,1,1,0,0,0,20'd8,16'h0, 1, 1'b0, 2'b11, 16'h9ABC, "R10");
    // R9: upper address bits ignored
    cyc(0,1,0,1,0,0,20'h00403,16'h4321, 0, 1'b0, 2'b00, 16'h0, "");
    cyc(0,1,1,1,0,0,20'h00403,16'h0, 0, 1'b0, 2'b00, 16'h0, "");
    cyc(0,1,1,0,0,0,20'h00003,16'h0, 1, 1'b0, 2'b11, 16'h4321, "R9");
    cyc(0,1,1,0,0,0,20'hFFC03,16'h0, 1, 1'b0, 2'b11, 16'h4321, "R9");
    // R3: read request with both byte enables high
    cyc(0,1,1,0,1,1,20'd3,16'h0, 1, 1'b1, 2'b00, 16'h0, "R3");
    // R2: read request with ce_n high
    cyc(1,1,1,0,0,0,20'd3,16'h0, 1, 1'b1, 2'b00, 16'h0, "R2");
    // R8: write with oe_n high also stores, then read back
    cyc(0,1,0,1,0,0,20'd11,16'hBEEF, 1, 1'b0, 2'b00, 16'h0, "R8");
    cyc(0,1,1,1,0,0,20'd11,16'h0, 0, 1'b0, 2'b00, 16'h0, "");
    cyc(0,1,1,0,0,0,20'd11,16'h0, 1, 1'b0, 2'b11, 16'hBEEF, "R4");
    cyc(1,0,1,1,1,1,20'd0,16'h0, 0, 1'b1, 2'b00, 16'h0, "");
    repeat (3) @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule